// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This unit takes a small set of asynchronous interrupt pins from outside the chip. For each pin it detects a trigger condition that software chooses, and it produces one masked request line per pin. Each pin can be set to trigger on a high level, a low level, a rising edge, a falling edge, or both edges. Level triggers follow the pin directly. Edge triggers set a sticky pending flag, which software acknowledges by writing a clear bit.

Configuration sits in 32-bit words, and each word serves four pins. Pin k is controlled by word k/4, slot k mod 4, so a six-pin build uses two words. The requests are also placed into a wider source vector at a fixed base index. A downstream interrupt aggregator can then take them as a contiguous run of cascaded sources.

Top module: `exti_ctrl`

## Requirements
- R1: Pin k uses word k/4 and slot s = k mod 4. Within a word the fields are: enable at bit s, polarity at bit 4+s, any-edge at bit 8+s, level-select at bit 12+s, and acknowledge at bit 16+s. A written word reads back on `cfg_rdata` one clock after its index is presented on `cfg_addr`.
- R2: After reset every pin has level-select 1, polarity 0, any-edge 0 and enable 0. `irq_req` and `agg_src` are zero. Word 0 reads 0x0000F000, and word 1 of a six-pin build reads 0x00003000.
- R3: With level-select 1 and polarity 1, an enabled request equals the pin level three clock edges after the pin changes. It has no memory.
- R4: With level-select 1 and polarity 0, an enabled request equals the inverted pin level three clock edges after the pin changes.
- R5: With level-select 0, polarity 1 and any-edge 0, a rising pin sets the pending flag. The request rises four clock edges after the pin change and stays high after the pin falls.
- R6: With level-select 0, polarity 0 and any-edge 0, only a falling pin sets the pending flag. A rising pin does not.
- R7: With level-select 0 and any-edge 1, both pin edges set the pending flag, whatever the polarity bit holds.
- R8: With enable 0 the request stays low, but an edge still sets the pending flag. Setting enable later raises the request one clock after the write takes effect.
- R9: Writing 1 to a pin's acknowledge bit drops that pin's pending flag, and the request falls one clock later. The pending flags of other pins are kept. Acknowledge bits always read as 0.
- R10: An edge detected in the same clock as the acknowledge write for that pin wins, and the pending flag stays set.
- R11: `agg_src` carries `irq_req[k]` at bit CASCADE_BASE+k (24+k by default) and zero on every other bit.
- R12: Slots with no pin behind them, and word indices beyond the last word, ignore writes and read as zero. Bits 31:16 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin_i | input | NUM_PINS | Asynchronous interrupt pins |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_addr | input | ADDR_W | Word index for write and read |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data for `cfg_addr` |
| irq_req | output | NUM_PINS | Registered masked request per pin |
| agg_src | output | SRC_W | Requests placed at the cascade base for an aggregator |

## Verification
A level-mode request is due three clock edges after a pin change: two synchroniser flops and the request register. An edge-mode request is due four edges after the change, because the pending flag adds one more register. A configuration or acknowledge write takes effect at the edge that samples it, and the request follows one edge later. Read data lags the index by one edge. The bench drives inputs on falling edges and counts rising edges to the due cycle. For each pin and mode it also samples one edge early to confirm the result has not appeared before its time. The acknowledge collision case places the write exactly on the edge where the synchronised edge is detected.

// File: rtl/exti_pkg.sv
package exti_pkg;
  localparam int SLOTS    = 4;
  localparam int REG_BITS = 32;
  localparam int F_MASK   = 0;
  localparam int F_SENSE  = 4;
  localparam int F_BOTH   = 8;
  localparam int F_LEVEL  = 12;
  localparam int F_CLR    = 16;

  typedef struct packed {
    logic level;
    logic sense;
    logic both;
    logic mask;
  } pin_cfg_t;

  localparam pin_cfg_t CFG_RESET = '{level: 1'b1, sense: 1'b0, both: 1'b0, mask: 1'b0};
endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
  parameter int NUM_PINS = 6,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] din,
  output logic [NUM_PINS-1:0] dout
);
  logic [NUM_PINS-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= din;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/exti_cfg_regs.sv
module exti_cfg_regs
  import exti_pkg::*;
#(
  parameter int NUM_PINS = 6,
  parameter int ADDR_W   = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           we,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [REG_BITS-1:0]            wdata,
  output pin_cfg_t [NUM_PINS-1:0]        cfg_q,
  output logic [NUM_PINS-1:0]            clr_pulse,
  output logic [REG_BITS-1:0]            rdata
);
  logic [REG_BITS-1:0] rd_next;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int RI = p / SLOTS;
    localparam int SL = p % SLOTS;
    logic     hit;
    pin_cfg_t q;

    assign hit = we && (addr == ADDR_W'(RI));

    always_ff @(posedge clk) begin
      if (rst) begin
        q <= CFG_RESET;
      end else if (hit) begin
        q <= '{level: wdata[F_LEVEL+SL], sense: wdata[F_SENSE+SL],
               both:  wdata[F_BOTH+SL],  mask:  wdata[F_MASK+SL]};
      end
    end

    assign cfg_q[p]     = q;
    assign clr_pulse[p] = hit && wdata[F_CLR+SL];
  end

  always_comb begin
    rd_next = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      if (addr == ADDR_W'(p / SLOTS)) begin
        rd_next[F_MASK  + p % SLOTS] = cfg_q[p].mask;
        rd_next[F_SENSE + p % SLOTS] = cfg_q[p].sense;
        rd_next[F_BOTH  + p % SLOTS] = cfg_q[p].both;
        rd_next[F_LEVEL + p % SLOTS] = cfg_q[p].level;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/exti_detect.sv
module exti_detect
  import exti_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_PINS-1:0]     lvl_in,
  input  pin_cfg_t [NUM_PINS-1:0] cfg,
  input  logic [NUM_PINS-1:0]     clr,
  output logic [NUM_PINS-1:0]     pend,
  output logic [NUM_PINS-1:0]     req
);
  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] hit;
  logic [NUM_PINS-1:0] pend_n;
  logic [NUM_PINS-1:0] req_n;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall, sel;
    assign rise      = lvl_in[p] & ~prev_q[p];
    assign fall      = ~lvl_in[p] & prev_q[p];
    assign sel       = cfg[p].both ? (rise | fall) : (cfg[p].sense ? rise : fall);
    assign hit[p]    = ~cfg[p].level & sel;
    // a fresh edge outranks an acknowledge in the same cycle
    assign pend_n[p] = hit[p] | (pend[p] & ~clr[p]);
    assign req_n[p]  = cfg[p].mask &
                       (cfg[p].level ? (lvl_in[p] == cfg[p].sense) : pend[p]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend   <= '0;
      req    <= '0;
    end else begin
      prev_q <= lvl_in;
      pend   <= pend_n;
      req    <= req_n;
    end
  end
endmodule

// File: rtl/exti_ctrl.sv
module exti_ctrl
  import exti_pkg::*;
#(
  parameter int NUM_PINS     = 6,
  parameter int ADDR_W       = 2,
  parameter int SYNC_STAGES  = 2,
  parameter int SRC_W        = 32,
  parameter int CASCADE_BASE = 24,
  parameter bit CASCADE      = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] ext_pin_i,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [31:0]         cfg_wdata,
  output logic [31:0]         cfg_rdata,
  output logic [NUM_PINS-1:0] irq_req,
  output logic [SRC_W-1:0]    agg_src
);
  logic [NUM_PINS-1:0]     sync_lvl;
  pin_cfg_t [NUM_PINS-1:0] cfg_q;
  logic [NUM_PINS-1:0]     clr_pulse;
  logic [NUM_PINS-1:0]     pend;

  exti_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ext_pin_i), .dout(sync_lvl));

  exti_cfg_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .cfg_q(cfg_q), .clr_pulse(clr_pulse), .rdata(cfg_rdata));

  exti_detect #(.NUM_PINS(NUM_PINS)) u_det (
    .clk(clk), .rst(rst), .lvl_in(sync_lvl), .cfg(cfg_q), .clr(clr_pulse),
    .pend(pend), .req(irq_req));

  if (CASCADE) begin : g_casc
    assign agg_src = SRC_W'(irq_req) << CASCADE_BASE;
  end else begin : g_nocasc
    assign agg_src = '0;
  end
endmodule

// File: rtl/exti_ctrl_chk.sv
module exti_ctrl_chk
  import exti_pkg::*;
#(
  parameter int NUM_PINS = 6
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NUM_PINS-1:0]     sync_lvl,
  input pin_cfg_t [NUM_PINS-1:0] cfg,
  input logic [NUM_PINS-1:0]     clr,
  input logic [NUM_PINS-1:0]     pend,
  input logic [NUM_PINS-1:0]     irq_req,
  input logic [31:0]             rdata
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
      !cfg[p].mask |=> !irq_req[p]);
    a_r3_level_high: assert property (@(posedge clk) disable iff (rst)
      (cfg[p].level && cfg[p].sense && cfg[p].mask) |=> irq_req[p] == $past(sync_lvl[p]));
    a_r4_level_low: assert property (@(posedge clk) disable iff (rst)
      (cfg[p].level && !cfg[p].sense && cfg[p].mask) |=> irq_req[p] == !$past(sync_lvl[p]));
    a_r5_pending_sticky: assert property (@(posedge clk) disable iff (rst)
      (pend[p] && !clr[p]) |=> pend[p]);
    a_r9_clear_drops: assert property (@(posedge clk) disable iff (rst)
      (clr[p] && $stable(sync_lvl[p])) |=> !pend[p]);
    a_r10_edge_wins: assert property (@(posedge clk) disable iff (rst)
      (clr[p] && !cfg[p].level && cfg[p].both && !$stable(sync_lvl[p])) |=> pend[p]);
  end

  a_r12_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rdata[31:16] == 16'h0000);
endmodule

bind exti_ctrl exti_ctrl_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst(rst), .sync_lvl(sync_lvl), .cfg(cfg_q), .clr(clr_pulse),
  .pend(pend), .irq_req(irq_req), .rdata(cfg_rdata));

// File: tb/sim_exti_ctrl.sv
`timescale 1ns/1ps
module sim_exti_ctrl;
  localparam int NP = 6;
  localparam int BASE = 24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NP-1:0] irq_req;
  logic [31:0] agg_src;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit bm [NP];
  bit bs [NP];
  bit bb [NP];
  bit bl [NP];

  always #2.5 clk = ~clk;

  exti_ctrl u0 (
    .clk(clk), .rst(rst), .ext_pin_i(pins), .cfg_we(we), .cfg_addr(addr),
    .cfg_wdata(wdata), .cfg_rdata(rdata), .irq_req(irq_req), .agg_src(agg_src));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] word(int r);
    logic [31:0] w = '0;
    for (int p = 0; p < NP; p++) begin
      if (p / 4 == r) begin
        w[p%4] = bm[p]; w[4+p%4] = bs[p]; w[8+p%4] = bb[p]; w[12+p%4] = bl[p];
      end
    end
    return w;
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    we = 1'b1; addr = 2'(a); wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(int a, output logic [31:0] v);
    addr = 2'(a);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic cfg_pin(int p, bit l, bit s, bit b, bit m);
    bl[p] = l; bs[p] = s; bb[p] = b; bm[p] = m;
    wr(p / 4, word(p / 4));
  endtask

  task automatic clr_pin(int p);
    wr(p / 4, word(p / 4) | (32'h1 << (16 + p % 4)));
  endtask

  task automatic chk_req(string tag, logic [NP-1:0] exp);
    check(tag, 32'(irq_req), 32'(exp));
    check({tag, " R11 cascade"}, agg_src, 32'(exp) << BASE);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int p = 0; p < NP; p++) begin bl[p] = 1; bs[p] = 0; bb[p] = 0; bm[p] = 0; end
    step(4);
    rst = 1'b0;
    step(1);
    // R2 reset state
    chk_req("R2 reset req", '0);
    rd(0, v); check("R2 reset word0", v, 32'h0000F000);
    rd(1, v); check("R2 reset word1", v, 32'h00003000);

    // R1 field placement and readback
    wr(0, 32'h000F_A5C3);
    rd(0, v); check("R1 readback word0", v, 32'h0000A5C3);
    wr(0, word(0) | 32'h000F_0000);
    rd(0, v); check("R1 restored word0", v, 32'h0000F000);

    // R12 unused slots and out-of-range index
    wr(1, 32'hFFFF_FFFF);
    rd(1, v); check("R12 unused slots", v, 32'h00003333);
    wr(2, 32'hFFFF_FFFF);
    rd(2, v); check("R12 out of range read", v, 32'h0);
    rd(0, v); check("R12 word0 untouched", v, 32'h0000F000);
    rd(1, v); check("R12 word1 untouched", v, 32'h00003333);
    wr(1, word(1) | 32'h000F_0000);
    step(2);
    chk_req("R12 quiet", '0);

    // sweep: every pin through every trigger mode
    for (int p = 0; p < NP; p++) begin
      for (int m = 0; m < 6; m++) begin
        bit l, s, b, pnd;
        string tg;
        logic [NP-1:0] one;
        one = '0; one[p] = 1'b1;
        l = (m < 2); s = (m == 0) || (m == 2) || (m == 4); b = (m >= 4);
        tg = l ? (s ? "R3" : "R4") : (b ? "R7" : (s ? "R5" : "R6"));
        cfg_pin(p, l, s, b, 1'b1);
        clr_pin(p);
        step(3);
        chk_req({tg, " idle low"}, (l && !s) ? one : '0);
        pins[p] = 1'b1;
        step(2);
        chk_req({tg, " not before due"}, (l && !s) ? one : '0);
        step(1);
        chk_req({tg, " three edges after rise"}, (l && s) ? one : '0);
        step(1);
        pnd = !l && (b || s);
        chk_req({tg, " four edges after rise"}, l ? (s ? one : '0) : (pnd ? one : '0));
        pins[p] = 1'b0;
        step(4);
        pnd = pnd || (!l && (b || !s));
        chk_req({tg, " after fall"}, l ? (s ? '0 : one) : (pnd ? one : '0));
        if (!l) begin
          clr_pin(p);
          step(1);
          chk_req({tg, " R9 acknowledged"}, '0);
        end
        cfg_pin(p, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1);
      end
    end
    rd(0, v); check("R9 acknowledge reads zero", v, 32'h0000F000);

    // R8 masked edge retained
    cfg_pin(1, 1'b0, 1'b1, 1'b0, 1'b0);
    clr_pin(1);
    pins[1] = 1'b1;
    step(5);
    chk_req("R8 masked quiet", '0);
    cfg_pin(1, 1'b0, 1'b1, 1'b0, 1'b1);
    step(1);
    chk_req("R8 pending revealed", 6'b000010);
    pins[1] = 1'b0;
    step(4);
    clr_pin(1);
    cfg_pin(1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(1);

    // R9 neighbour kept
    cfg_pin(2, 1'b0, 1'b1, 1'b0, 1'b1);
    cfg_pin(3, 1'b0, 1'b1, 1'b0, 1'b1);
    clr_pin(2); clr_pin(3);
    pins[2] = 1'b1; pins[3] = 1'b1;
    step(5);
    chk_req("R9 two pending", 6'b001100);
    clr_pin(2);
    step(1);
    chk_req("R9 neighbour kept", 6'b001000);

    // R10 edge collides with acknowledge
    pins[2] = 1'b0;
    step(4);
    pins[2] = 1'b1;
    step(2);
    clr_pin(2);
    step(1);
    chk_req("R10 edge wins", 6'b001100);
    pins[2] = 1'b0; pins[3] = 1'b0;
    step(4);
    wr(0, word(0) | 32'h000F_0000);
    step(1);
    chk_req("R10 cleanup", '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule